// File: doc/BRIEF.md
# Framebuffer scan address generator

This block produces the halfword read addresses that a display scan-out engine uses to walk a framebuffer. Software programs a bank number, a start base, an end base, a page width (halfwords of visible data per line) and a skip count (halfwords stepped over after each line, so that the visible window can sit inside a wider virtual screen). All addresses are in 16-bit halfword units. The output address joins the bank field above the in-bank base.

A timing generator drives a frame-start strobe at the top of each frame and a line-start strobe before each visible line. A fetch engine raises fetch-ready whenever it can accept an address. Each accepted read advances the address by one halfword. After a full page width the line closes, and the next line begins at the previous line's first address plus page width plus skip. When the halfword just below the end base has been read, the block raises end-of-frame. It issues no further reads until the next frame-start.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset, rd_valid and eof are 0. A line_start before the first frame_start starts no reads.
- R2: frame_start reloads the current address and the line base from cfg_start_base and clears eof and any open line. It takes priority over every other input in the same cycle.
- R3: rd_valid equals (line open AND fetch_rdy). rd_addr carries the latched bank in its upper 9 bits and the 21-bit in-bank base in its lower 21 bits.
- R4: Each accepted read (rd_valid high at a clock edge) advances the base by exactly one halfword. When fetch_rdy is low, the address holds.
- R5: A line opened by line_start closes after exactly page-width accepted reads. rd_valid stays 0 until the next line_start. A line_start while a line is open is ignored.
- R6: Each new line starts at the previous line's first address plus page width plus skip. With a skip of 0, the lines are contiguous.
- R7: When a read at address end_base-1 is accepted, eof rises on the next cycle and stays high until frame_start. While eof is high, line_start opens no line and rd_valid stays 0.
- R8: The base wraps modulo 2^21. The bank field never changes within a frame.
- R9: Bank, end base, page width and skip are captured at frame_start. Changing them mid-frame has no effect until the next frame_start.
- R10: With a captured page width of 0, line_start opens no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bank | input | 9 | Bank number placed above the in-bank base |
| cfg_start_base | input | 21 | Halfword base of the first pixel |
| cfg_end_base | input | 21 | Halfword base one past the last fetched halfword |
| cfg_page_width | input | 10 | Halfwords fetched per visible line |
| cfg_skip | input | 11 | Halfwords skipped after each line |
| frame_start | input | 1 | Frame start strobe |
| line_start | input | 1 | Line start strobe |
| fetch_rdy | input | 1 | Fetch engine can accept an address |
| rd_valid | output | 1 | Read address valid this cycle |
| rd_addr | output | 30 | Halfword read address {bank, base} |
| eof | output | 1 | Frame fully fetched |

## Verification
The hardest situation to reach is end-of-frame landing in the middle of a line, combined with a base that wraps past the top of the bank. Reaching it needs a start base two halfwords below 2^21, an end base placed after the wrap, and a page width larger than the frame's remaining length. The bench programs exactly that and checks three things: the bank bits stay put across the wrap, reads stop partway through the line, and later line_start strobes stay dead. A second hard case is the interleaving of stalls with line boundaries. A bench task that toggles fetch_rdy on every other cycle shows that the address moves only on accepted reads, including the jump by page width plus skip.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
   localparam int unsigned DEF_BANK_W = 9;
   localparam int unsigned DEF_BASE_W = 21;
   localparam int unsigned DEF_PAGE_W = 10;
   localparam int unsigned DEF_SKIP_W = 11;

   typedef enum logic [1:0] {
      SCAN_IDLE = 2'd0,
      SCAN_RUN  = 2'd1,
      SCAN_DONE = 2'd2
   } scan_state_e;
endpackage

// File: rtl/fbscan_line_ctr.sv
module fbscan_line_ctr #(
   parameter int unsigned PAGE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              open_req,
   input  logic              step,
   input  logic              kill,
   input  logic [PAGE_W-1:0] page_w,
   output logic              active,
   output logic              last
);
   logic [PAGE_W-1:0] cnt_q;

   initial assert (PAGE_W >= 1) else $error("PAGE_W must be at least 1");

   assign last = (PAGE_W'(cnt_q + 1'b1) == page_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (clr) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (step) begin
         if (last || kill) begin
            active <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= PAGE_W'(cnt_q + 1'b1);
         end
      end else if (open_req && !active) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end
   end

   // R5: a line opens only after a line request
   a_r5_open_needs_req : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(open_req));
   // R5: counting happens only inside an open line
   a_r5_step_in_line : assert property (@(posedge clk) disable iff (!rst_n)
      step |-> active);
endmodule

// File: rtl/fbscan_addr_step.sv
module fbscan_addr_step #(
   parameter int unsigned BASE_W  = 21,
   parameter int unsigned PAGE_W  = 10,
   parameter int unsigned SKIP_W  = 11,
   parameter bit          SKIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BASE_W-1:0] load_base,
   input  logic              step,
   input  logic              line_end,
   input  logic [PAGE_W-1:0] page_w,
   input  logic [SKIP_W-1:0] skip,
   output logic [BASE_W-1:0] cur
);
   logic [BASE_W-1:0] line_base_q;
   logic [BASE_W-1:0] stride;
   logic [BASE_W-1:0] next_line;

   initial assert (BASE_W >= PAGE_W && BASE_W >= SKIP_W)
      else $error("BASE_W must cover PAGE_W and SKIP_W");

   generate
      if (SKIP_EN) begin : g_skip
         assign stride = BASE_W'(page_w) + BASE_W'(skip);
      end else begin : g_noskip
         logic unused_skip;
         assign unused_skip = ^skip;
         assign stride = BASE_W'(page_w);
      end
   endgenerate

   assign next_line = BASE_W'(line_base_q + stride);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur         <= '0;
         line_base_q <= '0;
      end else if (load) begin
         cur         <= load_base;
         line_base_q <= load_base;
      end else if (step) begin
         if (line_end) begin
            cur         <= next_line;
            line_base_q <= next_line;
         end else begin
            cur <= BASE_W'(cur + 1'b1);
         end
      end
   end

   // R4: an in-line accepted read moves the base by one
   a_r4_step_plus_one : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !line_end && !load) |=> (cur == BASE_W'($past(cur) + 1'b1)));
   // R4: with no step and no load the base holds
   a_r4_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cur));
endmodule

// File: rtl/fbscan_end_det.sv
module fbscan_end_det #(
   parameter int unsigned BASE_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [BASE_W-1:0] cur,
   input  logic [BASE_W-1:0] end_base,
   output logic              hit,
   output logic              eof
);
   assign hit = step && (BASE_W'(cur + 1'b1) == end_base);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eof <= 1'b0;
      else if (clr)    eof <= 1'b0;
      else if (hit)    eof <= 1'b1;
   end

   // R7: end of frame holds until the next frame start
   a_r7_eof_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (eof && !clr) |=> eof);
   // R2: frame start always clears end of frame
   a_r2_clr_eof : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !eof);
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen
   import fbscan_pkg::*;
#(
   parameter int unsigned BANK_W  = DEF_BANK_W,
   parameter int unsigned BASE_W  = DEF_BASE_W,
   parameter int unsigned PAGE_W  = DEF_PAGE_W,
   parameter int unsigned SKIP_W  = DEF_SKIP_W,
   parameter bit          SKIP_EN = 1'b1,
   localparam int unsigned ADDR_W = BANK_W + BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] cfg_bank,
   input  logic [BASE_W-1:0] cfg_start_base,
   input  logic [BASE_W-1:0] cfg_end_base,
   input  logic [PAGE_W-1:0] cfg_page_width,
   input  logic [SKIP_W-1:0] cfg_skip,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              fetch_rdy,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              eof
);
   scan_state_e       state_q;
   logic [BANK_W-1:0] bank_q;
   logic [BASE_W-1:0] end_q;
   logic [PAGE_W-1:0] pw_q;
   logic [SKIP_W-1:0] skip_q;
   logic              line_active;
   logic              line_last;
   logic              end_hit;
   logic              open_req;
   logic              step;
   logic [BASE_W-1:0] cur;

   initial assert (BANK_W >= 1 && BASE_W >= 2) else $error("bad address split");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SCAN_IDLE;
         bank_q  <= '0;
         end_q   <= '0;
         pw_q    <= '0;
         skip_q  <= '0;
      end else if (frame_start) begin
         state_q <= SCAN_RUN;
         bank_q  <= cfg_bank;
         end_q   <= cfg_end_base;
         pw_q    <= cfg_page_width;
         skip_q  <= cfg_skip;
      end else if (end_hit) begin
         state_q <= SCAN_DONE;
      end
   end

   assign open_req = line_start && !frame_start && (state_q == SCAN_RUN)
                     && !eof && (pw_q != '0);
   assign rd_valid = line_active && fetch_rdy && !eof;
   assign step     = rd_valid && !frame_start;
   assign rd_addr  = {bank_q, cur};

   fbscan_line_ctr #(.PAGE_W(PAGE_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_start),
      .open_req (open_req),
      .step     (step),
      .kill     (end_hit),
      .page_w   (pw_q),
      .active   (line_active),
      .last     (line_last)
   );

   fbscan_addr_step #(
      .BASE_W  (BASE_W),
      .PAGE_W  (PAGE_W),
      .SKIP_W  (SKIP_W),
      .SKIP_EN (SKIP_EN)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_start),
      .load_base (cfg_start_base),
      .step      (step),
      .line_end  (line_last),
      .page_w    (pw_q),
      .skip      (skip_q),
      .cur       (cur)
   );

   fbscan_end_det #(.BASE_W(BASE_W)) u_end (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_start),
      .step     (step),
      .cur      (cur),
      .end_base (end_q),
      .hit      (end_hit),
      .eof      (eof)
   );

   // R3: no read is offered without fetch-ready
   a_r3_valid_needs_rdy : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> fetch_rdy);
   // R7: no read is offered once the frame has ended
   a_r7_no_read_after_eof : assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> !rd_valid);
   // R8, R9: the bank holds between frame starts
   a_r9_bank_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(bank_q));
   // R10: a zero page width never opens a line
   a_r10_zero_width : assert property (@(posedge clk) disable iff (!rst_n)
      (pw_q == '0 && !frame_start) |=> !line_active);
endmodule

// File: tb/test_fb_scan_addr_gen.sv
module test_fb_scan_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  cfg_bank = '0;
   logic [20:0] cfg_start_base = '0;
   logic [20:0] cfg_end_base = '0;
   logic [9:0]  cfg_page_width = '0;
   logic [10:0] cfg_skip = '0;
   logic        frame_start = 1'b0;
   logic        line_start = 1'b0;
   logic        fetch_rdy = 1'b0;
   logic        rd_valid;
   logic [29:0] rd_addr;
   logic        eof;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fb_scan_addr_gen i_fb_scan_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_bank(cfg_bank),
      .cfg_start_base(cfg_start_base), .cfg_end_base(cfg_end_base),
      .cfg_page_width(cfg_page_width), .cfg_skip(cfg_skip),
      .frame_start(frame_start), .line_start(line_start),
      .fetch_rdy(fetch_rdy), .rd_valid(rd_valid), .rd_addr(rd_addr), .eof(eof)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic setup(input logic [8:0] bank, input logic [20:0] sb,
                        input logic [20:0] eb, input logic [9:0] pw,
                        input logic [10:0] sk);
      cfg_bank = bank; cfg_start_base = sb; cfg_end_base = eb;
      cfg_page_width = pw; cfg_skip = sk;
      frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0; #1;
   endtask

   task automatic open_line();
      line_start = 1'b1;
      @(negedge clk); line_start = 1'b0; #1;
   endtask

   // fetch n halfwords; with stall, a not-ready cycle precedes every odd read
   task automatic fetch(input string req, input logic [8:0] bank,
                        input logic [20:0] first, input int n, input bit stall);
      logic [20:0] a;
      a = first;
      for (int i = 0; i < n; i++) begin
         if (stall && (i % 2 == 1)) begin
            fetch_rdy = 1'b0; #1;
            chk({req, " stall valid"}, 64'(rd_valid), 64'd0);
            @(negedge clk); #1;
         end
         fetch_rdy = 1'b1; #1;
         chk({req, " valid"}, 64'(rd_valid), 64'd1);
         chk({req, " addr"}, 64'(rd_addr), 64'({bank, a}));
         @(negedge clk); #1;
         a = 21'(a + 1);
      end
      fetch_rdy = 1'b0; #1;
   endtask

   task automatic idle_check(input string req);
      fetch_rdy = 1'b1; #1;
      chk({req, " no read"}, 64'(rd_valid), 64'd0);
      @(negedge clk); #1;
      chk({req, " no read later"}, 64'(rd_valid), 64'd0);
      fetch_rdy = 1'b0; #1;
   endtask

   task automatic t_reset();
      chk("R1 valid at reset", 64'(rd_valid), 64'd0);
      chk("R1 eof at reset", 64'(eof), 64'd0);
      open_line();
      idle_check("R1 line_start before frame_start");
   endtask

   task automatic t_contiguous();
      setup(9'h003, 21'd100, 21'd112, 10'd4, 11'd0);
      chk("R2 eof cleared", 64'(eof), 64'd0);
      idle_check("R5 no line before line_start");
      for (int l = 0; l < 3; l++) begin
         open_line();
         fetch("R6 contiguous line", 9'h003, 21'(100 + 4 * l), 4, 1'b0);
         if (l < 2) begin
            chk("R5 line closed", 64'(rd_valid | eof), 64'd0);
            idle_check("R5 after page width");
         end
      end
      chk("R7 eof raised", 64'(eof), 64'd1);
      open_line();
      idle_check("R7 line_start after eof");
      chk("R7 eof held", 64'(eof), 64'd1);
   endtask

   task automatic t_skip_stall();
      setup(9'h1a5, 21'd1000, 21'd1011, 10'd3, 11'd5);
      open_line();
      fetch("R4 stalled line", 9'h1a5, 21'd1000, 3, 1'b1);
      open_line();
      fetch("R6 skip line", 9'h1a5, 21'd1008, 3, 1'b1);
      chk("R7 eof after skip frame", 64'(eof), 64'd1);
   endtask

   task automatic t_restart_and_ignore();
      setup(9'h011, 21'd500, 21'd600, 10'd6, 11'd2);
      open_line();
      fetch("R4 partial", 9'h011, 21'd500, 2, 1'b0);
      open_line();
      fetch("R5 line_start ignored mid-line", 9'h011, 21'd502, 1, 1'b0);
      // R9: config changes mid-frame have no effect
      cfg_bank = 9'h0ff; cfg_page_width = 10'd2; cfg_skip = 11'd0; cfg_end_base = 21'd504;
      fetch("R9 old config kept", 9'h011, 21'd503, 3, 1'b0);
      open_line();
      fetch("R9 old stride", 9'h011, 21'd508, 2, 1'b0);
      chk("R9 old end kept", 64'(eof), 64'd0);
      // R2: frame start mid-line restarts the frame
      fetch_rdy = 1'b1;
      setup(9'h011, 21'd700, 21'd800, 10'd4, 11'd0);
      chk("R2 line closed by frame_start", 64'(rd_valid), 64'd0);
      fetch_rdy = 1'b0; #1;
      open_line();
      fetch("R2 reload", 9'h011, 21'd700, 4, 1'b0);
   endtask

   task automatic t_wrap_midline_eof();
      setup(9'h005, 21'h1ffffe, 21'd2, 10'd8, 11'd0);
      open_line();
      fetch("R8 wrap", 9'h005, 21'h1ffffe, 4, 1'b0);
      chk("R7 eof mid-line", 64'(eof), 64'd1);
      idle_check("R7 stop mid-line");
   endtask

   task automatic t_zero_width();
      setup(9'h001, 21'd10, 21'd20, 10'd0, 11'd3);
      open_line();
      idle_check("R10 zero page width");
      chk("R10 eof stays low", 64'(eof), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_contiguous();
      t_skip_stall();
      t_restart_and_ignore();
      t_wrap_midline_eof();
      t_zero_width();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule